// File: doc/BRIEF.md
# Transceiver Bring-Up Supervisor

This block oversees the start-up of a serial transceiver link. It watches the completion flags that a separate reset controller reports for the transmit and receive sides. If a stage fails to finish in time, it asks that controller for a new reset. It does nothing after power-up until software issues its first link-wide reset request. From then on it handles the start-up without further help: the transmit side first, then the receive side. Each stage has a watchdog of a fixed length in cycles. When a watchdog runs out, the block issues a single-cycle request for the reset that matches the stage.

Once both sides are up, the block reports the link as ready. If a data-quality input is driven, the block also watches it, and it restarts the receive side each time the input reports bad data. A saturating retry counter records how many reset requests have been issued, for debug. Only the power-on reset clears this counter. A build parameter selects whether the receive restart asks for the receive PLL together with the receive datapath, for designs with a separate receive PLL, or for the receive datapath only, for designs where one PLL serves both directions.

Top module: `xcvr_bringup_supervisor`

## Requirements
- R1: After power-on reset, and until the first `user_reset_all` pulse, `init_done` is 0, `retry_count` is 0 and no reset request is issued, even when every done input is high.
- R2: After the arming pulse, the block waits for both transmit done inputs and only then for both receive done inputs. `init_done` goes high in the cycle after the edge where both receive flags are sampled high.
- R3: If both transmit done inputs are not seen high within `TIMEOUT_CYCLES` cycles of entering the transmit wait, `tx_reset_all_pulse` is high for exactly one cycle, starting `TIMEOUT_CYCLES` cycles after that entry. A fresh transmit wait then begins.
- R4: If the receive wait times out in the same way, a one-cycle receive reset request is issued. This is `rx_pll_dp_reset_pulse` when `SHARED_PLL` is 0 and `rx_dp_reset_pulse` when it is 1. The other receive request stays low.
- R5: Every reset request cycle increments `retry_count` on the next edge. The count stops at `RETRY_SAT`.
- R6: `retry_count` is never cleared by `user_reset_all`. A `user_reset_all` pulse after arming has no effect on the state or the outputs.
- R7: While `init_done` is high, `rx_data_good` low on an edge causes a receive reset request in the next cycle, drops `init_done` and restarts the receive wait. This repeats for as long as the data stays bad.
- R8: After any reset request, done flags that are still high from before the request are not accepted. Completion counts only after the pair has been seen low at least once in the wait.
- R9: With `rx_data_good` held high, the block stays in the ready state with no further requests.
- R10: At most one reset request output is high in any cycle, and no request lasts longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| user_reset_all | input | 1 | Software link reset pulse; the first one arms the block |
| tx_pll_done | input | 1 | Transmit PLL reset complete (level, synchronous) |
| tx_dp_done | input | 1 | Transmit datapath reset complete (level, synchronous) |
| rx_pll_done | input | 1 | Receive PLL reset complete (level, synchronous) |
| rx_dp_done | input | 1 | Receive datapath reset complete (level, synchronous) |
| rx_data_good | input | 1 | Active-high data-quality indication; tie high to disable monitoring |
| init_done | output | 1 | Link brought up and operational |
| retry_count | output | RETRY_W | Saturating count of issued reset requests |
| tx_reset_all_pulse | output | 1 | One-cycle request for a full reset |
| rx_pll_dp_reset_pulse | output | 1 | One-cycle request for receive PLL and datapath reset |
| rx_dp_reset_pulse | output | 1 | One-cycle request for receive datapath reset |

## Verification
On every cycle, the embedded properties check the following. Only one reset request is active at a time, and each request lasts one cycle. The counter steps by one and then holds at saturation. An idle block stays idle without its arming pulse. A timeout and a bad-data sample each lead straight to the matching request. A request is always followed by a fresh receive or transmit wait. The bench scenarios are needed for the things these properties cannot show. They check the exact cycle of each timeout request. They check the rejection of done flags that stay high through a reset, and recovery once the controller resumes. They also check that the counter survives software resets, and that the shared-PLL build issues its datapath request in the same cycle as the separate-PLL build.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_TX_WAIT = 3'd1,
    ST_TX_RST  = 3'd2,
    ST_RX_WAIT = 3'd3,
    ST_RX_RST  = 3'd4,
    ST_OPER    = 3'd5
  } sup_state_e;

  typedef struct packed {
    logic tx_all;
    logic rx_pll_dp;
    logic rx_dp;
  } reset_req_t;

endpackage

// File: rtl/bringup_rst_sync.sv
module bringup_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  // Assert asynchronously, release after STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/bringup_timeout.sv
module bringup_timeout #(
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int CNT_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (run & (cnt_q != '0));
    cnt_d  = load ? RELOAD : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = run & (cnt_q == '0);

  // R3: an exhausted timer never wraps while the wait continues
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && (cnt_q == '0)) |=> (cnt_q == '0));

  // R3: each new wait starts from the full window
  a_r3_full_window: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == RELOAD));

endmodule

// File: rtl/bringup_retry_ctr.sv
module bringup_retry_ctr #(
  parameter int RETRY_SAT = 255,
  parameter int RETRY_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  output logic [RETRY_W-1:0] count
);

  localparam logic [RETRY_W-1:0] SAT = RETRY_W'(RETRY_SAT);

  logic [RETRY_W-1:0] count_q;
  logic               count_en;

  assign count_en = inc & (count_q != SAT);

  // Only the power-on reset clears the count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_q + RETRY_W'(1);
    end
  end

  assign count = count_q;

  // R5: one step per request below saturation
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && (count_q != SAT)) |=> (count_q == $past(count_q) + RETRY_W'(1)));

  // R5: saturation holds
  a_r5_hold_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == SAT) |=> (count_q == SAT));

  // R6: nothing but a request moves the count
  a_r6_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count_q));

endmodule

// File: rtl/bringup_done_gate.sv
module bringup_done_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic watch,
  input  logic pll_done,
  input  logic dp_done,
  output logic complete
);

  logic pair_ok;
  logic stale_q;
  logic stale_d;
  logic stale_en;

  assign pair_ok = pll_done & dp_done;

  // A reset request marks the flags stale; seeing them low clears it.
  always_comb begin
    stale_en = arm | (watch & ~pair_ok);
    stale_d  = arm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stale_q <= 1'b0;
    end else if (stale_en) begin
      stale_q <= stale_d;
    end
  end

  assign complete = watch & pair_ok & ~stale_q;

  // R8: the wait right after a request never completes at once
  a_r8_stale_block: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !complete);

  // R2: completion only with both flags high
  a_r2_pair_needed: assert property (@(posedge clk) disable iff (!rst_n)
    complete |-> (pll_done && dp_done));

endmodule

// File: rtl/bringup_fsm.sv
module bringup_fsm
  import bringup_pkg::*;
#(
  parameter bit SHARED_PLL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       user_reset_all,
  input  logic       tx_complete,
  input  logic       rx_complete,
  input  logic       expired,
  input  logic       rx_data_good,
  output logic       timer_load,
  output logic       timer_run,
  output logic       tx_arm,
  output logic       rx_arm,
  output logic       tx_watch,
  output logic       rx_watch,
  output logic       retry_inc,
  output logic       init_done,
  output reset_req_t req
);

  sup_state_e state_q;
  sup_state_e state_d;
  logic       next_is_wait;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (user_reset_all) state_d = ST_TX_WAIT;
      ST_TX_WAIT: begin
        if (tx_complete)  state_d = ST_RX_WAIT;
        else if (expired) state_d = ST_TX_RST;
      end
      ST_TX_RST:  state_d = ST_TX_WAIT;
      ST_RX_WAIT: begin
        if (rx_complete)  state_d = ST_OPER;
        else if (expired) state_d = ST_RX_RST;
      end
      ST_RX_RST:  state_d = ST_RX_WAIT;
      ST_OPER:    if (!rx_data_good) state_d = ST_RX_RST;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    next_is_wait = (state_d == ST_TX_WAIT) || (state_d == ST_RX_WAIT);
    timer_load   = next_is_wait && (state_d != state_q);
    timer_run    = (state_q == ST_TX_WAIT) || (state_q == ST_RX_WAIT);
    tx_watch     = (state_q == ST_TX_WAIT);
    rx_watch     = (state_q == ST_RX_WAIT);
    tx_arm       = (state_q == ST_TX_RST);
    rx_arm       = (state_q == ST_TX_RST) || (state_q == ST_RX_RST);
    retry_inc    = (state_q == ST_TX_RST) || (state_q == ST_RX_RST);
    init_done    = (state_q == ST_OPER);
  end

  assign req.tx_all = (state_q == ST_TX_RST);

  generate
    if (SHARED_PLL) begin : g_shared
      assign req.rx_dp     = (state_q == ST_RX_RST);
      assign req.rx_pll_dp = 1'b0;
    end else begin : g_split
      assign req.rx_pll_dp = (state_q == ST_RX_RST);
      assign req.rx_dp     = 1'b0;
    end
  endgenerate

  // R1: without the arming pulse the block stays idle
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && !user_reset_all) |=> (state_q == ST_IDLE));

  // R3: transmit timeout leads straight to the full reset request
  a_r3_tx_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_TX_WAIT) && expired && !tx_complete) |=> req.tx_all);

  // R4: a receive request is followed by a fresh receive wait
  a_r4_rx_return: assert property (@(posedge clk) disable iff (!rst_n)
    (req.rx_pll_dp || req.rx_dp) |=> (state_q == ST_RX_WAIT));

  // R7: bad data while operational triggers a receive request
  a_r7_bad_data: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !rx_data_good) |=> ((req.rx_pll_dp || req.rx_dp) && !init_done));

  // R10: the full reset request lasts one cycle
  a_r10_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
    req.tx_all |=> !req.tx_all);

endmodule

// File: rtl/xcvr_bringup_supervisor.sv
module xcvr_bringup_supervisor
  import bringup_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1024,
  parameter int RETRY_SAT      = 255,
  parameter int RETRY_W        = $clog2(RETRY_SAT + 1),
  parameter bit SHARED_PLL     = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               user_reset_all,
  input  logic               tx_pll_done,
  input  logic               tx_dp_done,
  input  logic               rx_pll_done,
  input  logic               rx_dp_done,
  input  logic               rx_data_good,
  output logic               init_done,
  output logic [RETRY_W-1:0] retry_count,
  output logic               tx_reset_all_pulse,
  output logic               rx_pll_dp_reset_pulse,
  output logic               rx_dp_reset_pulse
);

  logic       rst_n_int;
  logic       timer_load;
  logic       timer_run;
  logic       expired;
  logic       tx_arm;
  logic       rx_arm;
  logic       tx_watch;
  logic       rx_watch;
  logic       tx_complete;
  logic       rx_complete;
  logic       retry_inc;
  reset_req_t req;

  bringup_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  bringup_timeout #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timeout (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load    (timer_load),
    .run     (timer_run),
    .expired (expired)
  );

  bringup_done_gate u_tx_gate (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .arm      (tx_arm),
    .watch    (tx_watch),
    .pll_done (tx_pll_done),
    .dp_done  (tx_dp_done),
    .complete (tx_complete)
  );

  bringup_done_gate u_rx_gate (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .arm      (rx_arm),
    .watch    (rx_watch),
    .pll_done (rx_pll_done),
    .dp_done  (rx_dp_done),
    .complete (rx_complete)
  );

  bringup_fsm #(.SHARED_PLL(SHARED_PLL)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .user_reset_all (user_reset_all),
    .tx_complete    (tx_complete),
    .rx_complete    (rx_complete),
    .expired        (expired),
    .rx_data_good   (rx_data_good),
    .timer_load     (timer_load),
    .timer_run      (timer_run),
    .tx_arm         (tx_arm),
    .rx_arm         (rx_arm),
    .tx_watch       (tx_watch),
    .rx_watch       (rx_watch),
    .retry_inc      (retry_inc),
    .init_done      (init_done),
    .req            (req)
  );

  bringup_retry_ctr #(.RETRY_SAT(RETRY_SAT), .RETRY_W(RETRY_W)) u_retry (
    .clk   (clk),
    .rst_n (rst_n_int),
    .inc   (retry_inc),
    .count (retry_count)
  );

  assign tx_reset_all_pulse    = req.tx_all;
  assign rx_pll_dp_reset_pulse = req.rx_pll_dp;
  assign rx_dp_reset_pulse     = req.rx_dp;

  // R10: never two requests at once
  a_r10_one_request: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0({tx_reset_all_pulse, rx_pll_dp_reset_pulse, rx_dp_reset_pulse}));

  // R10: a receive request lasts one cycle
  a_r10_rx_single: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rx_pll_dp_reset_pulse || rx_dp_reset_pulse) |=> !(rx_pll_dp_reset_pulse || rx_dp_reset_pulse));

endmodule

// File: tb/xcvr_bringup_supervisor_tb_top.sv
`timescale 1ns/1ps
module xcvr_bringup_supervisor_tb_top;

  localparam int TO  = 16;
  localparam int SAT = 5;
  localparam int RW  = $clog2(SAT + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, user_reset_all, rx_data_good;
  logic tx_pll_done, tx_dp_done, rx_pll_done, rx_dp_done;
  logic init_done, tx_p, rxpd_p, rxd_p;
  logic [RW-1:0] retry_count;
  logic s_init_done, s_tx_p, s_rxpd_p, s_rxd_p;
  logic [RW-1:0] s_retry_count;

  int cyc = 0;
  int tx_delay, rx_delay, tx_cnt, rx_cnt;
  bit blk_tx_dp, rx_sticky;
  int n_cmp = 0;
  int n_bad = 0;

  typedef struct { int kind; int at; string req; } exp_t;
  exp_t exp_q[$];

  xcvr_bringup_supervisor #(.TIMEOUT_CYCLES(TO), .RETRY_SAT(SAT), .SHARED_PLL(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .user_reset_all(user_reset_all),
    .tx_pll_done(tx_pll_done), .tx_dp_done(tx_dp_done),
    .rx_pll_done(rx_pll_done), .rx_dp_done(rx_dp_done), .rx_data_good(rx_data_good),
    .init_done(init_done), .retry_count(retry_count), .tx_reset_all_pulse(tx_p),
    .rx_pll_dp_reset_pulse(rxpd_p), .rx_dp_reset_pulse(rxd_p));

  xcvr_bringup_supervisor #(.TIMEOUT_CYCLES(TO), .RETRY_SAT(SAT), .SHARED_PLL(1'b1)) dut_shared_i (
    .clk(clk), .rst_n(rst_n), .user_reset_all(user_reset_all),
    .tx_pll_done(tx_pll_done), .tx_dp_done(tx_dp_done),
    .rx_pll_done(rx_pll_done), .rx_dp_done(rx_dp_done), .rx_data_good(rx_data_good),
    .init_done(s_init_done), .retry_count(s_retry_count), .tx_reset_all_pulse(s_tx_p),
    .rx_pll_dp_reset_pulse(s_rxpd_p), .rx_dp_reset_pulse(s_rxd_p));

  always @(posedge clk) cyc <= cyc + 1;

  // Reset controller model: done flags rise a programmable delay after a request.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cnt <= 0;
      rx_cnt <= 0;
    end else if (user_reset_all || tx_p) begin
      tx_cnt <= tx_delay;
      rx_cnt <= tx_delay + rx_delay;
    end else begin
      if (tx_cnt > 0) tx_cnt <= tx_cnt - 1;
      if ((rxpd_p || rxd_p) && !rx_sticky) rx_cnt <= rx_delay;
      else if (rx_cnt > 0) rx_cnt <= rx_cnt - 1;
    end
  end

  assign tx_pll_done = (tx_cnt == 0);
  assign tx_dp_done  = (tx_cnt == 0) && !blk_tx_dp;
  assign rx_pll_done = (rx_cnt == 0);
  assign rx_dp_done  = (rx_cnt == 0);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic expect_req(input int kind, input int at, input string req);
    exp_t e;
    e.kind = kind; e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  // Scoreboard monitor: every request pulse must match the head of the queue.
  always @(negedge clk) begin
    int n;
    int kind;
    exp_t e;
    n = int'(tx_p) + int'(rxpd_p) + int'(rxd_p);
    kind = tx_p ? 1 : (rxpd_p ? 2 : (rxd_p ? 3 : 0));
    if (n > 1) check(1'b0, "R10", "simultaneous requests", n, 1);
    if (n == 1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected request kind", kind, 0);
      end else begin
        e = exp_q.pop_front();
        check(kind == e.kind, e.req, "request kind", kind, e.kind);
        check(cyc == e.at, e.req, "request cycle", cyc, e.at);
      end
    end
    if (n > 0 || s_tx_p || s_rxpd_p || s_rxd_p) begin
      // R4: shared-PLL build issues the datapath-only request in lockstep
      check(s_rxd_p == rxpd_p && !s_rxpd_p && s_tx_p == tx_p, "R4",
            "shared build request vector", {s_tx_p, s_rxpd_p, s_rxd_p}, {tx_p, 1'b0, rxpd_p});
    end
  end

  task automatic tick_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic user_pulse(output int c0);
    user_reset_all = 1'b1;
    @(negedge clk);
    user_reset_all = 1'b0;
    c0 = cyc;
  endtask

  task automatic power_reset();
    rst_n = 1'b0;
    blk_tx_dp = 1'b0;
    rx_sticky = 1'b0;
    rx_data_good = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish (cycle %0d)", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int c0;
    int c;
    rst_n = 1'b0; user_reset_all = 1'b0; rx_data_good = 1'b1;
    tx_delay = 3; rx_delay = 4; blk_tx_dp = 1'b0; rx_sticky = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);

    // R1: idle with every done flag high
    check(init_done == 1'b0, "R1", "init_done before arming", init_done, 0);
    check(retry_count == '0, "R1", "retry_count after reset", retry_count, 0);

    // R2: nominal bring-up, ready 8 cycles after the arming edge
    user_pulse(c0);
    tick_to(c0 + 7);
    check(init_done == 1'b0, "R2", "init_done one cycle early", init_done, 0);
    tick_to(c0 + 8);
    check(init_done == 1'b1, "R2", "init_done after both stages", init_done, 1);

    // R9: stays operational with good data
    repeat (40) @(negedge clk);
    check(init_done == 1'b1, "R9", "init_done held", init_done, 1);
    check(retry_count == '0, "R9", "no retries", retry_count, 0);

    // R6: a later user pulse has no effect
    user_pulse(c0);
    repeat (20) @(negedge clk);
    check(init_done == 1'b1, "R6", "init_done after late user pulse", init_done, 1);
    check(retry_count == '0, "R6", "retry_count after late user pulse", retry_count, 0);

    // R7: bad data triggers repeated receive restarts
    c = cyc;
    rx_data_good = 1'b0;
    expect_req(2, c + 1, "R7");
    expect_req(2, c + 8, "R7");
    tick_to(c + 3);
    check(init_done == 1'b0, "R7", "init_done after bad data", init_done, 0);
    tick_to(c + 9);
    rx_data_good = 1'b1;
    tick_to(c + 13);
    check(init_done == 1'b0, "R7", "init_done before recovery", init_done, 0);
    tick_to(c + 14);
    check(init_done == 1'b1, "R7", "init_done after recovery", init_done, 1);
    check(retry_count == RW'(2), "R5", "retry_count after two restarts", retry_count, 2);

    // R8: done flags that never drop are not accepted after a request
    repeat (5) @(negedge clk);
    c = cyc;
    rx_sticky = 1'b1;
    rx_data_good = 1'b0;
    expect_req(2, c + 1, "R8");
    expect_req(2, c + 2 + TO, "R8");
    tick_to(c + 2);
    rx_data_good = 1'b1;
    tick_to(c + 10);
    check(init_done == 1'b0, "R8", "stale flags rejected", init_done, 0);
    rx_sticky = 1'b0;
    tick_to(c + 7 + TO);
    check(init_done == 1'b0, "R8", "init_done before fresh flags", init_done, 0);
    tick_to(c + 8 + TO);
    check(init_done == 1'b1, "R8", "init_done after fresh flags", init_done, 1);

    // R3: transmit timeout with the datapath flag held low
    power_reset();
    check(retry_count == '0, "R6", "power-on reset clears count", retry_count, 0);
    tx_delay = 3; rx_delay = 4; blk_tx_dp = 1'b1;
    user_pulse(c0);
    expect_req(1, c0 + TO, "R3");
    tick_to(c0 + TO + 1);
    blk_tx_dp = 1'b0;
    check(retry_count == RW'(1), "R3", "retry_count after tx timeout", retry_count, 1);
    tick_to(c0 + TO + 8);
    check(init_done == 1'b0, "R3", "init_done before retry completes", init_done, 0);
    tick_to(c0 + TO + 9);
    check(init_done == 1'b1, "R3", "init_done after tx retry", init_done, 1);

    // R4: receive timeout, both builds
    power_reset();
    tx_delay = 3; rx_delay = 100;
    user_pulse(c0);
    expect_req(2, c0 + 4 + TO, "R4");
    tick_to(c0 + 10);
    rx_delay = 4;
    tick_to(c0 + 9 + TO);
    check(init_done == 1'b0, "R4", "init_done before rx retry completes", init_done, 0);
    tick_to(c0 + 10 + TO);
    check(init_done == 1'b1, "R4", "init_done after rx retry", init_done, 1);
    check(s_init_done == 1'b1, "R4", "shared build init_done", s_init_done, 1);
    check(retry_count == RW'(1), "R4", "retry_count after rx timeout", retry_count, 1);

    // R5: saturation under endless transmit timeouts
    power_reset();
    tx_delay = 3; rx_delay = 4;
    blk_tx_dp = 1'b1;
    user_pulse(c0);
    for (int k = 0; k < 7; k++) expect_req(1, c0 + TO + k * (TO + 1), "R5");
    tick_to(c0 + TO + 2 * (TO + 1) + 1);
    check(retry_count == RW'(3), "R5", "retry_count after three requests", retry_count, 3);
    user_pulse(c);
    tick_to(c0 + TO + 3 * (TO + 1) + 1);
    check(retry_count == RW'(4), "R6", "user pulse leaves count counting", retry_count, 4);
    tick_to(c0 + TO + 6 * (TO + 1) + 1);
    check(retry_count == RW'(SAT), "R5", "retry_count saturated", retry_count, SAT);
    power_reset();

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R10", "outstanding expected requests", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule